// File: doc/BRIEF.md
# Burst Read-Modify-Write Engine

This block is a memory-mapped bus master that walks a fixed-length array of 32-bit signed words in memory. On a start request it reads the whole array into a local buffer using incrementing bursts. It then writes every word back to the address it came from, with a constant added. Read and write traffic use separate channel sets. A write phase begins only after the last read beat has arrived.

Each burst is sized to the smallest of three limits: the burst ceiling (16 beats), the words still to move, and the words left before the next 4 KB address boundary. A 50-word array from an aligned base therefore moves as 16, 16, 16 and 2 beats. Only one write burst is outstanding at a time, and the engine waits for its response before issuing the next write address. A small control interface supplies the start pulse and the base address, and reports busy, done and a sticky error flag. The error flag records a bad response or a burst whose last-beat marker is out of place.

Top module: `rmw_burst_engine`

## Requirements
- R1: After reset, busy, done and err are 0, and arvalid, awvalid and wvalid are 0.
- R2: A start pulse while idle latches base_addr with its two low bits forced to zero, clears done and err, and raises busy on the next cycle. A start pulse while busy has no effect on the addresses issued.
- R3: Every burst carries len = beats-1, where beats = min(16, words remaining, words left before the next 4096-byte boundary). Burst addresses are contiguous and increasing from the base. The size field is 2 (4 bytes) and the burst-type field is 1 (incrementing).
- R4: All 50 read beats are accepted before the first write address is presented.
- R5: Each word written equals the word read from the same address plus 100, with 32-bit wrap-around, and wstrb is all ones.
- R6: wlast is 1 on the final beat of each write burst and 0 on every other beat.
- R7: A read burst whose rlast does not match the expected final beat sets err.
- R8: A nonzero rresp (any non-OKAY code) or bresp sets err. The flag stays set through the rest of the operation, which still completes, and the next start clears it.
- R9: At most one write burst is outstanding: no write address is issued until the previous write response has been accepted. done rises only after the final write response.
- R10: While a valid is high and its ready is low, the valid stays high and the address, length, data and last fields stay unchanged.
- R11: busy is 1 from the cycle after an accepted start until done. done stays 1 while idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only when idle |
| base_addr | input | 32 | Byte address of the first array word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (sticky until next start) |
| err | output | 1 | Sticky error: bad response or last-beat mismatch |
| araddr | output | 32 | Read burst address |
| arlen | output | 8 | Read burst beats minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Final read beat marker |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| awaddr | output | 32 | Write burst address |
| awlen | output | 8 | Write burst beats minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wlast | output | 1 | Final write beat marker |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
If the word index or beat counter goes wrong, the error is visible on the bus within one burst. A burst length or address differs from the plan, or wlast lands on the wrong beat. If the buffer is written or read at the wrong slot, nothing shows during the read phase. The error appears only in the write-back data, one full read phase later, so the bench compares every memory word after each run. A phase sequencing fault is caught at the first write address it affects: an early write, a second outstanding write burst, or an early done. The bench uses back-pressure, boundary-crossing bases and delayed responses to expose these.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ADDR,
      ST_RD_DATA,
      ST_WR_ADDR,
      ST_WR_DATA,
      ST_WR_RESP
   } rmw_state_e;

   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/rmw_burst_calc.sv
// Burst sizing: smallest of the burst ceiling, words remaining and, when
// enabled, words left before the address boundary.
module rmw_burst_calc #(
   parameter int MAX_BEATS   = 16,
   parameter int NUM_WORDS   = 50,
   parameter int SIZE_CODE   = 2,
   parameter int BOUND_BYTES = 4096,
   parameter int LIMIT_BOUND = 1,
   parameter int IDX_W       = 6,
   parameter int BEAT_W      = 5,
   parameter int BOUND_W     = 12
) (
   input  logic [BOUND_W-1:0] addr_off,
   input  logic [IDX_W-1:0]   words_done,
   output logic [BEAT_W-1:0]  beats
);

   logic [31:0] remain;
   logic [31:0] capped;
   logic [31:0] pick;

   always_comb begin
      remain = 32'(NUM_WORDS) - 32'(words_done);
      capped = (remain > 32'(MAX_BEATS)) ? 32'(MAX_BEATS) : remain;
   end

   generate
      if (LIMIT_BOUND != 0) begin : g_bound
         logic [31:0] room;
         always_comb begin
            room = (32'(BOUND_BYTES) - 32'(addr_off)) >> SIZE_CODE;
            pick = (capped > room) ? room : capped;
         end
      end else begin : g_flat
         logic unused_off;
         assign unused_off = ^addr_off;
         assign pick = capped;
      end
   endgenerate

   assign beats = pick[BEAT_W-1:0];

endmodule

// File: rtl/rmw_word_buf.sv
// Local array storage: one synchronous write port, one combinational read port.
module rmw_word_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 50,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rmw_burst_engine.sv
module rmw_burst_engine
   import rmw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_WORDS   = 50,
   parameter int MAX_BEATS   = 16,
   parameter int ADDEND      = 100,
   parameter int BOUND_BYTES = 4096,
   parameter int LIMIT_BOUND = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     base_addr,
   output logic                  busy,
   output logic                  done,
   output logic                  err,
   output logic [ADDR_W-1:0]     araddr,
   output logic [7:0]            arlen,
   output logic [2:0]            arsize,
   output logic [1:0]            arburst,
   output logic                  arvalid,
   input  logic                  arready,
   input  logic [DATA_W-1:0]     rdata,
   input  logic [1:0]            rresp,
   input  logic                  rlast,
   input  logic                  rvalid,
   output logic                  rready,
   output logic [ADDR_W-1:0]     awaddr,
   output logic [7:0]            awlen,
   output logic [2:0]            awsize,
   output logic [1:0]            awburst,
   output logic                  awvalid,
   input  logic                  awready,
   output logic [DATA_W-1:0]     wdata,
   output logic [DATA_W/8-1:0]   wstrb,
   output logic                  wlast,
   output logic                  wvalid,
   input  logic                  wready,
   input  logic [1:0]            bresp,
   input  logic                  bvalid,
   output logic                  bready
);

   localparam int BYTES     = DATA_W / 8;
   localparam int SIZE_CODE = $clog2(BYTES);
   localparam int IDX_W     = $clog2(NUM_WORDS + 1);
   localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
   localparam int BOUND_W   = $clog2(BOUND_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BYTES - 1);
   localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(NUM_WORDS - 1);
   localparam logic [IDX_W-1:0]  END_IDX    = IDX_W'(NUM_WORDS);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 8");
      end
      if (MAX_BEATS < 1 || MAX_BEATS > 256) begin : g_bad_beats
         $error("MAX_BEATS must lie in 1..256");
      end
      if (NUM_WORDS < 1) begin : g_bad_words
         $error("NUM_WORDS must be positive");
      end
      if ((BOUND_BYTES & (BOUND_BYTES - 1)) != 0 || BOUND_BYTES < BYTES) begin : g_bad_bound
         $error("BOUND_BYTES must be a power of two no smaller than one word");
      end
      if (BOUND_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must exceed the boundary offset width");
      end
   endgenerate

   rmw_state_e          state_q;
   logic [ADDR_W-1:0]   base_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [IDX_W-1:0]    idx_q;
   logic [BEAT_W-1:0]   beat_q;
   logic [BEAT_W-1:0]   len_q;
   logic                err_q;
   logic                done_q;

   logic [BEAT_W-1:0]   calc_beats;
   logic [DATA_W-1:0]   buf_rd;
   logic                beat_is_last;
   logic [ADDR_W-1:0]   addr_step;
   logic                buf_we;

   rmw_burst_calc #(
      .MAX_BEATS  (MAX_BEATS),
      .NUM_WORDS  (NUM_WORDS),
      .SIZE_CODE  (SIZE_CODE),
      .BOUND_BYTES(BOUND_BYTES),
      .LIMIT_BOUND(LIMIT_BOUND),
      .IDX_W      (IDX_W),
      .BEAT_W     (BEAT_W),
      .BOUND_W    (BOUND_W)
   ) u_calc (
      .addr_off  (addr_q[BOUND_W-1:0]),
      .words_done(idx_q),
      .beats     (calc_beats)
   );

   assign buf_we = (state_q == ST_RD_DATA) && rvalid;

   rmw_word_buf #(
      .DATA_W(DATA_W),
      .DEPTH (NUM_WORDS),
      .IDX_W (IDX_W)
   ) u_buf (
      .clk  (clk),
      .we   (buf_we),
      .waddr(idx_q),
      .wdata(rdata),
      .raddr(idx_q),
      .rdata(buf_rd)
   );

   assign beat_is_last = (beat_q == (len_q - BEAT_W'(1)));
   assign addr_step    = ADDR_W'(len_q) << SIZE_CODE;

   // read address channel
   assign araddr  = addr_q;
   assign arlen   = 8'(calc_beats) - 8'd1;
   assign arsize  = 3'(SIZE_CODE);
   assign arburst = BURST_INCR;
   assign arvalid = (state_q == ST_RD_ADDR);
   assign rready  = (state_q == ST_RD_DATA);

   // write address, data and response channels
   assign awaddr  = addr_q;
   assign awlen   = 8'(calc_beats) - 8'd1;
   assign awsize  = 3'(SIZE_CODE);
   assign awburst = BURST_INCR;
   assign awvalid = (state_q == ST_WR_ADDR);
   assign wvalid  = (state_q == ST_WR_DATA);
   assign wdata   = buf_rd + DATA_W'(ADDEND);
   assign wstrb   = '1;
   assign wlast   = (state_q == ST_WR_DATA) && beat_is_last;
   assign bready  = (state_q == ST_WR_RESP);

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign err  = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         addr_q  <= '0;
         idx_q   <= '0;
         beat_q  <= '0;
         len_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q  <= base_addr & ALIGN_MASK;
                  addr_q  <= base_addr & ALIGN_MASK;
                  idx_q   <= '0;
                  err_q   <= 1'b0;
                  done_q  <= 1'b0;
                  state_q <= ST_RD_ADDR;
               end
            end
            ST_RD_ADDR: begin
               if (arready) begin
                  len_q   <= calc_beats;
                  beat_q  <= '0;
                  state_q <= ST_RD_DATA;
               end
            end
            ST_RD_DATA: begin
               if (rvalid) begin
                  if (rresp != RESP_OKAY || rlast != beat_is_last) err_q <= 1'b1;
                  beat_q <= beat_q + BEAT_W'(1);
                  if (beat_is_last) begin
                     if (idx_q == LAST_IDX) begin
                        idx_q   <= '0;
                        addr_q  <= base_q;
                        state_q <= ST_WR_ADDR;
                     end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        addr_q  <= addr_q + addr_step;
                        state_q <= ST_RD_ADDR;
                     end
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            ST_WR_ADDR: begin
               if (awready) begin
                  len_q   <= calc_beats;
                  beat_q  <= '0;
                  state_q <= ST_WR_DATA;
               end
            end
            ST_WR_DATA: begin
               if (wready) begin
                  idx_q  <= idx_q + IDX_W'(1);
                  beat_q <= beat_q + BEAT_W'(1);
                  if (beat_is_last) state_q <= ST_WR_RESP;
               end
            end
            ST_WR_RESP: begin
               if (bvalid) begin
                  if (bresp != RESP_OKAY) err_q <= 1'b1;
                  if (idx_q == END_IDX) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     addr_q  <= addr_q + addr_step;
                     state_q <= ST_WR_ADDR;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rmw_burst_engine_chk.sv
module rmw_burst_engine_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_WORDS   = 50,
   parameter int MAX_BEATS   = 16,
   parameter int BOUND_BYTES = 4096,
   parameter int LIMIT_BOUND = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic [ADDR_W-1:0]   araddr,
   input logic [7:0]          arlen,
   input logic [2:0]          arsize,
   input logic [1:0]          arburst,
   input logic                arvalid,
   input logic                arready,
   input logic                rvalid,
   input logic                rready,
   input logic [ADDR_W-1:0]   awaddr,
   input logic [7:0]          awlen,
   input logic                awvalid,
   input logic                awready,
   input logic [DATA_W-1:0]   wdata,
   input logic [DATA_W/8-1:0] wstrb,
   input logic                wlast,
   input logic                wvalid,
   input logic                wready,
   input logic                bvalid,
   input logic                bready
);

   localparam int SIZE_CODE = $clog2(DATA_W / 8);
   localparam int BOUND_W   = $clog2(BOUND_BYTES);

   int rd_cnt;
   int outst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt <= 0;
         outst  <= 0;
      end else begin
         if (!busy) rd_cnt <= 0;
         else if (rvalid && rready) rd_cnt <= rd_cnt + 1;
         case ({awvalid && awready, bvalid && bready})
            2'b10:   outst <= outst + 1;
            2'b01:   outst <= outst - 1;
            default: outst <= outst;
         endcase
      end
   end

   p_ar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));
   p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
   p_w_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));
   p_reads_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> rd_cnt == NUM_WORDS);
   p_one_wburst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> outst == 0);
   p_done_after_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(bvalid && bready));
   p_arlen_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid |-> 32'(arlen) < MAX_BEATS);
   p_awlen_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> 32'(awlen) < MAX_BEATS);
   p_ar_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid |-> arsize == 3'(SIZE_CODE) && arburst == 2'b01);
   p_wstrb_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> &wstrb);
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   generate
      if (LIMIT_BOUND != 0) begin : g_bound_chk
         p_ar_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
            arvalid |-> 32'(araddr[BOUND_W-1:0]) + ((32'(arlen) + 1) << SIZE_CODE)
                        <= 32'(BOUND_BYTES));
         p_aw_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
            awvalid |-> 32'(awaddr[BOUND_W-1:0]) + ((32'(awlen) + 1) << SIZE_CODE)
                        <= 32'(BOUND_BYTES));
      end
   endgenerate

endmodule

bind rmw_burst_engine rmw_burst_engine_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NUM_WORDS  (NUM_WORDS),
   .MAX_BEATS  (MAX_BEATS),
   .BOUND_BYTES(BOUND_BYTES),
   .LIMIT_BOUND(LIMIT_BOUND)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .araddr (araddr),
   .arlen  (arlen),
   .arsize (arsize),
   .arburst(arburst),
   .arvalid(arvalid),
   .arready(arready),
   .rvalid (rvalid),
   .rready (rready),
   .awaddr (awaddr),
   .awlen  (awlen),
   .awvalid(awvalid),
   .awready(awready),
   .wdata  (wdata),
   .wstrb  (wstrb),
   .wlast  (wlast),
   .wvalid (wvalid),
   .wready (wready),
   .bvalid (bvalid),
   .bready (bready)
);

// File: tb/rmw_burst_engine_test.sv
module rmw_burst_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int N = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic        busy, done, err;
   logic [31:0] araddr, awaddr, wdata;
   logic [7:0]  arlen, awlen;
   logic [2:0]  arsize, awsize;
   logic [1:0]  arburst, awburst;
   logic        arvalid, awvalid, wvalid, wlast, rready, bready;
   logic [3:0]  wstrb;
   logic        arready = 1'b0, awready = 1'b0, wready = 1'b0;
   logic [31:0] rdata = '0;
   logic [1:0]  rresp = '0, bresp = '0;
   logic        rlast = 1'b0, rvalid = 1'b0, bvalid = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rmw_burst_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .busy(busy), .done(done), .err(err),
      .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
      .arvalid(arvalid), .arready(arready),
      .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready),
      .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
      .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
      .bresp(bresp), .bvalid(bvalid), .bready(bready)
   );

   // memory and slave model state
   logic [31:0] mem [0:2047];
   logic [31:0] expv [0:N-1];
   logic [15:0] lfsr = 16'hACE1;
   bit  bp = 0, b_hold = 0;
   int  inj_rresp_beat = -1, inj_bresp_burst = -1, inj_rlast_burst = -1;
   int  rd_act = 0, rd_a = 0, rd_left = 0, rd_bi = 0;
   int  wr_act = 0, wr_a = 0, wr_left = 0, wr_bi = 0, b_pend = 0, b_bi = 0;
   int  ar_n = 0, aw_n = 0, rd_total = 0, w_total = 0, b_count = 0;
   int  ar_addr_log [0:15], ar_len_log [0:15], aw_addr_log [0:15], aw_len_log [0:15];
   int  bad_attr = 0, order_viol = 0, wlast_bad = 0;
   int  vectors = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // bus slave model: reads pre-edge values, drives with nonblocking updates
   initial begin
      forever begin
         @(posedge clk);
         lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (rvalid && rready) begin
            rd_a++; rd_left--; rd_total++;
            if (rd_left == 0) rd_act = 0;
         end
         if (arvalid && arready) begin
            if (ar_n < 16) begin ar_addr_log[ar_n] = int'(araddr); ar_len_log[ar_n] = int'(arlen); end
            if (arsize != 3'd2 || arburst != 2'd1) bad_attr++;
            rd_bi = ar_n; ar_n++;
            rd_act = 1; rd_a = int'(araddr[12:2]); rd_left = int'(arlen) + 1;
         end
         if (!(rvalid && !rready)) begin
            if (rd_act != 0 && (!bp || lfsr[0])) begin
               rvalid <= 1'b1;
               rdata  <= mem[rd_a];
               rlast  <= (rd_left == 1) ^ (rd_left == 1 && rd_bi == inj_rlast_burst);
               rresp  <= (rd_total == inj_rresp_beat) ? 2'b10 : 2'b00;
            end else rvalid <= 1'b0;
         end
         arready <= !bp || lfsr[3];
         if (wvalid && wready) begin
            if (wr_act != 0) mem[wr_a] = wdata;
            if (wlast != (wr_left == 1) || wstrb != 4'hF) wlast_bad++;
            wr_a++; wr_left--; w_total++;
            if (wr_left == 0) begin wr_act = 0; b_pend = 1; b_bi = wr_bi; end
         end
         if (awvalid && awready) begin
            if (aw_n < 16) begin aw_addr_log[aw_n] = int'(awaddr); aw_len_log[aw_n] = int'(awlen); end
            if (awsize != 3'd2 || awburst != 2'd1) bad_attr++;
            if (rd_total < N) order_viol++;
            wr_bi = aw_n; aw_n++;
            wr_act = 1; wr_a = int'(awaddr[12:2]); wr_left = int'(awlen) + 1;
         end
         awready <= !bp || lfsr[5];
         wready  <= !bp || lfsr[7];
         if (bvalid && bready) bvalid <= 1'b0;
         else if (!bvalid && b_pend != 0 && !b_hold && (!bp || lfsr[11])) begin
            bvalid <= 1'b1;
            bresp  <= (b_bi == inj_bresp_burst) ? 2'b10 : 2'b00;
            b_pend = 0; b_count++;
         end
      end
   end

   function automatic int plan_beats(int a, int rem);
      int room = (4096 - (a % 4096)) / 4;
      int b = 16;
      if (rem < b) b = rem;
      if (room < b) b = room;
      return b;
   endfunction

   task automatic launch(input logic [31:0] b);
      for (int i = 0; i < N; i++) expv[i] = mem[(b[12:0] >> 2) + i] + 32'd100;
      ar_n = 0; aw_n = 0; rd_total = 0; w_total = 0; b_count = 0;
      bad_attr = 0; order_viol = 0; wlast_bad = 0;
      @(negedge clk); start = 1'b1; base_addr = b;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, "R11", "busy after start", busy, 1);
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic check_run(input logic [31:0] b, input bit exp_err);
      int a = int'(b & 32'hFFFF_FFFC);
      int moved = 0;
      int n = 0;
      int bad = 0;
      while (moved < N) begin
         int bt = plan_beats(a, N - moved);
         if (ar_addr_log[n] != a || ar_len_log[n] != bt - 1) bad++;
         if (aw_addr_log[n] != a || aw_len_log[n] != bt - 1) bad++;
         a += 4 * bt; moved += bt; n++;
      end
      chk(ar_n == n && aw_n == n, "R3", "burst count", ar_n, n);
      chk(bad == 0, "R3", "burst address/length mismatches", bad, 0);
      chk(bad_attr == 0, "R3", "size/type field errors", bad_attr, 0);
      chk(order_viol == 0, "R4", "writes before reads done", order_viol, 0);
      chk(wlast_bad == 0, "R6", "wlast/wstrb misplacements", wlast_bad, 0);
      bad = 0;
      for (int i = 0; i < N; i++)
         if (mem[(b[12:0] >> 2) + i] != expv[i]) bad++;
      chk(bad == 0, "R5", "written words off by add", bad, 0);
      chk(err == exp_err, "R8", "err flag", err, exp_err);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !err, "R1", "status after reset", {busy, done, err}, 0);
      chk(!arvalid && !awvalid && !wvalid, "R1", "valids after reset",
          {arvalid, awvalid, wvalid}, 0);
   endtask

   task automatic t_aligned();
      bp = 0;
      launch(32'h100); wait_done(); check_run(32'h100, 0);
   endtask

   task automatic t_stall();
      bp = 1;
      launch(32'h400); wait_done(); check_run(32'h400, 0);
      bp = 0;
   endtask

   task automatic t_boundary();
      bp = 1;
      launch(32'hFE0); wait_done(); check_run(32'hFE0, 0);
      chk(ar_len_log[0] == 7 && ar_len_log[3] == 9, "R3", "boundary first/last len",
          ar_len_log[0], 7);
      bp = 0;
   endtask

   task automatic t_unaligned();
      launch(32'h30A); wait_done(); check_run(32'h30A, 0);
      chk(ar_addr_log[0] == 32'h308, "R2", "low address bits dropped", ar_addr_log[0], 32'h308);
   endtask

   task automatic t_start_while_busy();
      logic [31:0] snap [0:N-1];
      int bad = 0;
      for (int i = 0; i < N; i++) snap[i] = mem[i];
      bp = 1;
      launch(32'h600);
      repeat (20) @(negedge clk);
      start = 1'b1; base_addr = 32'h0;
      @(negedge clk); start = 1'b0;
      wait_done(); check_run(32'h600, 0);
      for (int i = 0; i < N; i++) if (mem[i] != snap[i]) bad++;
      chk(bad == 0, "R2", "start while busy touched other area", bad, 0);
      bp = 0;
   endtask

   task automatic t_rresp_err();
      inj_rresp_beat = 20;
      launch(32'h800); wait_done(); check_run(32'h800, 1);
      inj_rresp_beat = -1;
      launch(32'h800); wait_done();
      chk(err == 1'b0, "R8", "err cleared by next start", err, 0);
   endtask

   task automatic t_bresp_err();
      inj_bresp_burst = 1;
      launch(32'hA00); wait_done(); check_run(32'hA00, 1);
      inj_bresp_burst = -1;
   endtask

   task automatic t_rlast_err();
      inj_rlast_burst = 2;
      launch(32'hC00); wait_done();
      chk(err == 1'b1, "R7", "rlast mismatch flagged", err, 1);
      inj_rlast_burst = -1;
   endtask

   task automatic t_bhold();
      int cum [0:3] = '{16, 32, 48, 50};
      b_hold = 1;
      launch(32'h1F00);
      for (int k = 0; k < 4; k++) begin
         while (w_total < cum[k]) @(negedge clk);
         repeat (6) @(negedge clk);
         chk(!awvalid && !done && aw_n == k + 1, "R9", "held response blocks progress",
             {awvalid, done}, 0);
         b_hold = 0;
         while (b_count < k + 1) @(negedge clk);
         b_hold = 1;
      end
      b_hold = 0;
      wait_done();
      check_run(32'h1F00, 0);
   endtask

   task automatic t_sticky_done();
      repeat (10) @(negedge clk);
      chk(done && !busy, "R11", "done held while idle", done, 1);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++)
         mem[i] = (i % 5 == 0) ? 32'h7FFF_FFC0 + 32'(i % 3) : 32'(i * 7919 - 40000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned();
      t_stall();
      t_boundary();
      t_unaligned();
      t_start_while_busy();
      t_rresp_err();
      t_bresp_err();
      t_rlast_err();
      t_bhold();
      t_sticky_done();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule